// File: doc/BRIEF.md
# Presettable Up/Down Counter with Cascade Outputs

An eight-bit synchronous counter that steps up or down on a slowed-down tick taken from the fast system clock. The count is held either as a plain binary value or as two decimal digits in BCD. Two further controls act at once on the next clock edge, with no wait for a tick. One forces the count to zero. The other copies an eight-bit preset into all bits together.

A terminal-count flag shows that the next step in the chosen direction will wrap. It goes high at the top value when counting up and at zero when counting down. A one-cycle ripple pulse marks the edge at which the wrap takes place, so several counters can be chained in a cascade. The prescaler ratio is a parameter. A ratio of 1 gives one step on every system clock cycle.

Top module: `updn_cnt`

## Requirements
- R1: While rst_ni is low the count is 0. After reset it stays 0 until a control changes it.
- R2: clear_i high forces the count to 0 on the next clock edge. It overrides load_i, en_i and the prescaler tick.
- R3: load_i high with clear_i low copies preset_i into the count on the next edge. This happens whatever en_i and the tick are doing.
- R4: With clear_i and load_i low and en_i low, the count holds.
- R5: With bcd_i=0 and a step taken, the count goes +1 when dir_up_i=1 and -1 when dir_up_i=0, modulo 256.
- R6: With bcd_i=1, bits [3:0] are the low digit and bits [7:4] the high digit. Counting up, a low digit past 9 becomes 0 and carries into the high digit, and 0x99 wraps to 0x00.
- R7: With bcd_i=1 counting down, a low digit of 0 becomes 9 and borrows from the high digit, and 0x00 wraps to 0x99.
- R8: A BCD digit above 9 is stored as loaded. An up step that reaches it moves it to 0 with a carry. A down step that reaches it lowers it by one.
- R9: term_o is high when dir_up_i=1 and the count is 0xFF in binary mode or 0x99 in BCD mode. It is also high when dir_up_i=0 and the count is 0x00. It is low otherwise.
- R10: ripple_o is high in a cycle only if a step is taken at the next edge (en_i high, tick present, clear_i and load_i low) and term_o is high.
- R11: Steps happen only on prescaler ticks, one tick every DIV clock cycles. With DIV=3, nine cycles after reset with counting enabled the count is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear to zero |
| load_i | input | 1 | Synchronous parallel load |
| preset_i | input | 8 | Value copied in on load |
| en_i | input | 1 | Count enable |
| dir_up_i | input | 1 | 1 counts up, 0 counts down |
| bcd_i | input | 1 | 1 selects two-digit BCD, 0 binary |
| count_o | output | 8 | Current count |
| term_o | output | 1 | Terminal count for the current direction and mode |
| ripple_o | output | 1 | Wrap pulse for cascading |

## Verification
The count register is visible directly on count_o, so a wrong step shows up on the port one edge after it happens. A digit-carry error in BCD mode can stay hidden until the low digit passes 9 or 0. The bench forces these points with presets such as 0x99, 0x00, 0x3C and 0xA9. A prescaler fault changes the step rate. It shows up only after a whole division period, which a second instance with a divide ratio of three exposes within nine cycles. Terminal-count and ripple errors are combinational and appear in the same cycle as the count that triggers them.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_STEP  = 2'd3
  } act_e;
endpackage

// File: rtl/updn_cnt_prescale.sv
module updn_cnt_prescale #(
  parameter int unsigned DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/updn_cnt_digit.sv
module updn_cnt_digit #(
  parameter int unsigned DW   = 4,
  parameter int unsigned MAXV = 9
) (
  input  logic [DW-1:0] d_i,
  input  logic          up_i,
  input  logic          cin_i,
  output logic [DW-1:0] d_o,
  output logic          cout_o
);
  localparam logic [DW-1:0] TOP = DW'(MAXV);
  always_comb begin
    d_o    = d_i;
    cout_o = 1'b0;
    if (cin_i) begin
      if (up_i) begin
        // out-of-range digits also roll to zero
        if (d_i >= TOP) begin
          d_o    = '0;
          cout_o = 1'b1;
        end else begin
          d_o = d_i + 1'b1;
        end
      end else begin
        if (d_i == '0) begin
          d_o    = TOP;
          cout_o = 1'b1;
        end else begin
          d_o = d_i - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/updn_cnt.sv
module updn_cnt
  import updn_cnt_pkg::*;
#(
  parameter int unsigned DIGITS  = 2,
  parameter int unsigned DIGIT_W = 4,
  parameter int unsigned DEC_MAX = 9,
  parameter int unsigned DIV     = 25_000_000
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       load_i,
  input  logic [DIGITS*DIGIT_W-1:0]  preset_i,
  input  logic                       en_i,
  input  logic                       dir_up_i,
  input  logic                       bcd_i,
  output logic [DIGITS*DIGIT_W-1:0]  count_o,
  output logic                       term_o,
  output logic                       ripple_o
);
  localparam int unsigned W = DIGITS * DIGIT_W;
  localparam logic [W-1:0] BCD_TOP = {DIGITS{DIGIT_W'(DEC_MAX)}};

  logic         tick;
  act_e         act;
  logic [W-1:0] cnt_q, bin_nxt, bcd_nxt, step_nxt;
  logic [DIGITS:0] carry;
  logic         unused_top_carry;

  updn_cnt_prescale #(.DIV(DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  assign carry[0] = 1'b1;
  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    updn_cnt_digit #(.DW(DIGIT_W), .MAXV(DEC_MAX)) u_dig (
      .d_i   (cnt_q[i*DIGIT_W +: DIGIT_W]),
      .up_i  (dir_up_i),
      .cin_i (carry[i]),
      .d_o   (bcd_nxt[i*DIGIT_W +: DIGIT_W]),
      .cout_o(carry[i+1])
    );
  end
  assign unused_top_carry = carry[DIGITS];

  assign bin_nxt  = dir_up_i ? cnt_q + 1'b1 : cnt_q - 1'b1;
  assign step_nxt = bcd_i ? bcd_nxt : bin_nxt;

  always_comb begin
    if (clear_i)            act = ACT_CLEAR;
    else if (load_i)        act = ACT_LOAD;
    else if (en_i && tick)  act = ACT_STEP;
    else                    act = ACT_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      unique case (act)
        ACT_CLEAR: cnt_q <= '0;
        ACT_LOAD:  cnt_q <= preset_i;
        ACT_STEP:  cnt_q <= step_nxt;
        default:   cnt_q <= cnt_q;
      endcase
    end
  end

  always_comb begin
    if (dir_up_i) term_o = bcd_i ? (cnt_q == BCD_TOP) : (cnt_q == '1);
    else          term_o = (cnt_q == '0);
  end

  assign ripple_o = (act == ACT_STEP) && term_o;
  assign count_o  = cnt_q;
endmodule

// File: rtl/updn_cnt_chk.sv
module updn_cnt_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clear_i,
  input logic         load_i,
  input logic [W-1:0] preset_i,
  input logic         en_i,
  input logic         dir_up_i,
  input logic         bcd_i,
  input logic         tick_i,
  input logic [W-1:0] count_i,
  input logic         term_i,
  input logic         ripple_i
);
  p_clear_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> count_i == '0);

  p_load_copy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !clear_i |=> count_i == $past(preset_i));

  p_hold_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i && !load_i && !en_i |=> $stable(count_i));

  p_bin_up_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i && !load_i && en_i && tick_i && !bcd_i && dir_up_i
    |=> count_i == W'($past(count_i) + 1'b1));

  p_bin_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i && !load_i && en_i && tick_i && !bcd_i && !dir_up_i
    |=> count_i == W'($past(count_i) - 1'b1));

  p_term_down_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_up_i && term_i |-> count_i == '0);

  p_ripple_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ripple_i |-> term_i && en_i && tick_i && !clear_i && !load_i);

  p_ripple_wraps_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ripple_i && dir_up_i |=> count_i == '0);

  p_no_tick_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !clear_i && !load_i |=> $stable(count_i));
endmodule

bind updn_cnt updn_cnt_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clear_i (clear_i),
  .load_i  (load_i),
  .preset_i(preset_i),
  .en_i    (en_i),
  .dir_up_i(dir_up_i),
  .bcd_i   (bcd_i),
  .tick_i  (tick),
  .count_i (count_o),
  .term_i  (term_o),
  .ripple_i(ripple_o)
);

// File: tb/updn_cnt_bench.sv
`timescale 1ns/1ps
module updn_cnt_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0, ld = 1'b0, en = 1'b0, up = 1'b1, bcd = 1'b0;
  logic [7:0] pre = '0;
  logic [7:0] cnt, cnt3;
  logic       term, rip, term3, rip3;
  logic [7:0] exp_c = '0;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  updn_cnt #(.DIV(1)) u_updn_cnt (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clr), .load_i(ld), .preset_i(pre),
    .en_i(en), .dir_up_i(up), .bcd_i(bcd),
    .count_o(cnt), .term_o(term), .ripple_o(rip)
  );

  updn_cnt #(.DIV(3)) u_updn_cnt_div3 (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(1'b0), .load_i(1'b0), .preset_i(8'h00),
    .en_i(1'b1), .dir_up_i(1'b1), .bcd_i(1'b0),
    .count_o(cnt3), .term_o(term3), .ripple_o(rip3)
  );

  function automatic logic [7:0] model(logic [7:0] c, logic cl, logic l, logic [7:0] p,
                                       logic e, logic u, logic b);
    logic [3:0] lo, hi;
    if (cl) return 8'h00;
    if (l) return p;
    if (!e) return c;
    if (!b) return u ? c + 8'd1 : c - 8'd1;
    lo = c[3:0];
    hi = c[7:4];
    if (u) begin
      if (lo >= 4'd9) begin
        lo = 4'd0;
        hi = (hi >= 4'd9) ? 4'd0 : hi + 4'd1;
      end else lo = lo + 4'd1;
    end else begin
      if (lo == 4'd0) begin
        lo = 4'd9;
        hi = (hi == 4'd0) ? 4'd9 : hi - 4'd1;
      end else lo = lo - 4'd1;
    end
    return {hi, lo};
  endfunction

  function automatic logic term_model(logic [7:0] c, logic u, logic b);
    if (!u) return c == 8'h00;
    return b ? (c == 8'h99) : (c == 8'hFF);
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, want, $time);
    end
  endtask

  // entered at a negedge; leaves at the next negedge
  task automatic apply(string tag, logic cl, logic l, logic [7:0] p,
                       logic e, logic u, logic b);
    clr = cl; ld = l; pre = p; en = e; up = u; bcd = b;
    #1;
    check("R9 term", {7'd0, term}, {7'd0, term_model(exp_c, u, b)});
    check("R10 ripple", {7'd0, rip}, {7'd0, (!cl && !l && e && term_model(exp_c, u, b))});
    @(posedge clk);
    exp_c = model(exp_c, cl, l, p, e, u, b);
    @(negedge clk);
    check(tag, cnt, exp_c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] p;
    logic cl, l, e, u;
    string tag;
    repeat (3) @(negedge clk);
    check("R1 reset", cnt, 8'h00);
    rst_n = 1'b1;
    repeat (9) @(negedge clk);
    check("R1 held after reset", cnt, 8'h00);
    check("R11 div3 after 9 cycles", cnt3, 8'd3);
    @(negedge clk);
    check("R11 div3 after 10 cycles", cnt3, 8'd3);

    // directed corners
    apply("R3 load while disabled", 0, 1, 8'h99, 0, 1, 1);
    apply("R6 99 wraps to 00", 0, 0, 8'h00, 1, 1, 1);
    apply("R2 clear beats load", 1, 1, 8'h55, 1, 1, 0);
    apply("R7 00 wraps to 99", 0, 0, 8'h00, 1, 0, 1);
    apply("R7 borrow 99->98", 0, 0, 8'h00, 1, 0, 1);
    apply("R3 load 40", 0, 1, 8'h40, 1, 0, 1);
    apply("R7 digit borrow 40->39", 0, 0, 8'h00, 1, 0, 1);
    apply("R8 load 3C kept", 0, 1, 8'h3C, 1, 1, 1);
    apply("R8 3C up to 40", 0, 0, 8'h00, 1, 1, 1);
    apply("R8 load A9", 0, 1, 8'hA9, 0, 1, 1);
    apply("R8 A9 up to 00", 0, 0, 8'h00, 1, 1, 1);
    apply("R8 load 3C", 0, 1, 8'h3C, 0, 0, 1);
    apply("R8 3C down to 3B", 0, 0, 8'h00, 1, 0, 1);
    apply("R5 load FF", 0, 1, 8'hFF, 0, 1, 0);
    apply("R5 FF wraps to 00", 0, 0, 8'h00, 1, 1, 0);
    apply("R5 00 down to FF", 0, 0, 8'h00, 1, 0, 0);
    apply("R4 hold", 0, 0, 8'h12, 0, 1, 0);

    void'($urandom(32'h1357));
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(31) == 0) bcd = ~bcd;
      cl = ($urandom_range(15) == 0);
      l  = ($urandom_range(7) == 0);
      e  = ($urandom_range(3) != 0);
      u  = ($urandom_range(1) == 1);
      if (bcd && $urandom_range(3) != 0) p = {4'($urandom_range(9)), 4'($urandom_range(9))};
      else p = 8'($urandom);
      if (cl) tag = "R2 random clear";
      else if (l) tag = "R3 random load";
      else if (!e) tag = "R4 random hold";
      else if (!bcd) tag = "R5 random binary step";
      else if (u) tag = "R6 random bcd up";
      else tag = "R7 random bcd down";
      apply(tag, cl, l, p, e, u, bcd);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule